// File: doc/BRIEF.md
# Queue-Aware Rank Power-Down Controller

This block sits inside a DRAM memory controller and decides, rank by rank, when to put a rank into power-down and when to bring it back. It watches each command as it leaves the command queue toward the DRAM. It also watches a vector that marks, for every rank, whether any command still waiting in the queue targets that rank. Each rank has an idle timer. The timer restarts from a reload value when the rank is accessed and counts down on a cycle tick. A rank is sent into power-down only when three things are true together: its timer has run out, it is not already in low power, and the queue holds nothing for it. That last condition is a lookahead. It keeps a rank awake when an access to it is about to arrive.

While a rank is powered down, a pending or issued command for it raises an exit request. The exit clears the rank's low-power status and starts a wake window. For a fixed number of cycles in that window the rank must not be accessed, and a per-rank stall flag tells the scheduler so. Every rank runs its own logic, so in any cycle several ranks may enter or leave power-down independently. The command input is observe-only. It has a valid qualifier but no ready, because this block never back-pressures the queue. It only advises the scheduler through the stall flags.

Top module: `rank_pd_ctrl`

## Requirements
- R1: While `rst_n` is low, `in_pd`, `pd_enter`, `pd_exit` and `wake_stall` are all zero. Every idle timer restarts at `IDLE_RELOAD`. With the defaults (4 ranks, reload 8, tick held high, no commands, nothing pending) a rank enters on the 9th clock edge after reset release.
- R2: A valid command with `cmd_rank` = r (binary rank index) reloads rank r's timer to `IDLE_RELOAD`. With the tick held high, rank r then enters power-down on the `IDLE_RELOAD`+2 th edge counted from the edge that sampled the command. That is 10 edges for the default.
- R3: A timer counts down only on edges where `tick` is high, and it stops at zero. While `tick` is low, a reloaded rank never enters power-down.
- R4: A rank enters power-down only when its timer is zero, its status is active, it has no pending command, and no command is issued to it in that cycle. On entry, `pd_enter[r]` is high for exactly one cycle, and `in_pd[r]` goes high on the same edge.
- R5: While `pend_vec[r]` is high, rank r does not enter power-down, however long its timer has been zero.
- R6: If a rank is in power-down and either `pend_vec[r]` is high or a valid command targets it, the next edge pulses `pd_exit[r]` for one cycle, clears `in_pd[r]` and reloads the rank's timer.
- R7: After an exit, `wake_stall[r]` is high for exactly `EXIT_LAT` cycles, starting with the cycle in which `pd_exit[r]` is high. No entry happens while it is high.
- R8: Ranks are independent. Several ranks can exit, or enter, on the same edge, and events on one rank do not change the timing of another.
- R9: When `cmd_valid` is low, `cmd_rank` is ignored. A rank named there with no pending command and a zero timer still enters on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Idle-timer count enable |
| cmd_valid | input | 1 | A command leaves the queue this cycle |
| cmd_rank | input | RANK_W | Binary rank index of that command |
| pend_vec | input | NUM_RANKS | Bit r high: a queued command targets rank r |
| pd_enter | output | NUM_RANKS | One-cycle power-down entry request per rank |
| pd_exit | output | NUM_RANKS | One-cycle power-down exit request per rank |
| wake_stall | output | NUM_RANKS | Rank must not be accessed (waking) |
| in_pd | output | NUM_RANKS | Low-power status per rank |

## Verification
Entry is tried in four ways:
- with the timer running out while the queue is empty, which shows the basic countdown;
- with the timer at zero but a pending command held, which separates the lookahead gate from the timer gate;
- with an issued command followed by a full countdown, which exposes the reload value and its edge count;
- with the tick held low, which shows that counting follows the tick and not the clock.

Exit is tried both from a pending flag and from a direct issue. It is also tried on two ranks at once, which tells shared logic apart from per-rank logic. An invalid command whose rank field names an eligible rank shows whether the valid qualifier is honoured. Every entry and exit pulse is matched by cycle and by rank against a queue of expected events, so an extra, missing or late pulse is caught.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

  typedef enum logic [1:0] {
    RK_ACTIVE = 2'd0,
    RK_DOWN   = 2'd1,
    RK_WAKE   = 2'd2
  } rk_mode_e;

endpackage

// File: rtl/rpd_rank_decode.sv
module rpd_rank_decode #(
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [RANK_W-1:0]    cmd_rank,
  output logic [NUM_RANKS-1:0] hit_vec
);

  always_comb begin
    hit_vec = '0;
    for (int r = 0; r < NUM_RANKS; r++) begin
      if (cmd_valid && (cmd_rank == RANK_W'(r))) hit_vec[r] = 1'b1;
    end
  end

  // R8: one command selects at most one rank
  p_single_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9: no rank is selected without a valid command
  p_invalid_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> ($countones(hit_vec) == 0));

endmodule

// File: rtl/rpd_idle_timer.sv
module rpd_idle_timer #(
  parameter int IDLE_RELOAD = 8,
  localparam int CNT_W = $clog2(IDLE_RELOAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(IDLE_RELOAD);
    end else if (load) begin
      cnt_q <= CNT_W'(IDLE_RELOAD);
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R2: an access restarts the countdown from the reload value
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == CNT_W'(IDLE_RELOAD)));

  // R3: without a tick the timer holds
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));

  // R3: an expired timer stays at zero until reloaded
  p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/rpd_rank_fsm.sv
module rpd_rank_fsm
  import rpd_pkg::*;
#(
  parameter int EXIT_LAT = 6,
  localparam int WK_W = $clog2(EXIT_LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_zero,
  input  logic hit,
  input  logic pend,
  output logic reload,
  output logic enter_p,
  output logic exit_p,
  output logic stall,
  output logic in_pd
);

  rk_mode_e        mode_q;
  logic [WK_W-1:0] wk_q;
  logic            go_down;
  logic            go_up;

  assign go_down = (mode_q == RK_ACTIVE) && idle_zero && !pend && !hit;
  assign go_up   = (mode_q == RK_DOWN) && (pend || hit);
  assign reload  = hit || go_up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= RK_ACTIVE;
      wk_q    <= '0;
      enter_p <= 1'b0;
      exit_p  <= 1'b0;
    end else begin
      enter_p <= go_down;
      exit_p  <= go_up;
      unique case (mode_q)
        RK_ACTIVE: if (go_down) mode_q <= RK_DOWN;
        RK_DOWN: begin
          if (go_up) begin
            mode_q <= RK_WAKE;
            wk_q   <= WK_W'(EXIT_LAT);
          end
        end
        RK_WAKE: begin
          if (wk_q <= WK_W'(1)) begin
            mode_q <= RK_ACTIVE;
            wk_q   <= '0;
          end else begin
            wk_q <= wk_q - 1'b1;
          end
        end
        default: mode_q <= RK_ACTIVE;
      endcase
    end
  end

  assign stall = (mode_q == RK_WAKE);
  assign in_pd = (mode_q == RK_DOWN);

  // R4: an entry pulse coincides with the status being set
  p_enter_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_p |-> in_pd);

  // R5: a pending command on an active rank blocks entry
  p_pend_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && (mode_q == RK_ACTIVE)) |=> !enter_p);

  // R6: exit clears a status that was set
  p_exit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exit_p |-> (!in_pd && $past(in_pd)));

  // R7: the wake window starts with the exit pulse
  p_exit_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_p |-> stall);

  // R7: no entry while waking
  p_no_enter_waking_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !enter_p);

  // R8: a rank never enters and exits in the same cycle
  p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_p && exit_p));

endmodule

// File: rtl/rank_pd_ctrl.sv
module rank_pd_ctrl #(
  parameter int NUM_RANKS   = 4,
  parameter int IDLE_RELOAD = 8,
  parameter int EXIT_LAT    = 6,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 cmd_valid,
  input  logic [RANK_W-1:0]    cmd_rank,
  input  logic [NUM_RANKS-1:0] pend_vec,
  output logic [NUM_RANKS-1:0] pd_enter,
  output logic [NUM_RANKS-1:0] pd_exit,
  output logic [NUM_RANKS-1:0] wake_stall,
  output logic [NUM_RANKS-1:0] in_pd
);

  logic [NUM_RANKS-1:0] hit_vec;
  logic [NUM_RANKS-1:0] idle_zero;
  logic [NUM_RANKS-1:0] reload;

  rpd_rank_decode #(
    .NUM_RANKS (NUM_RANKS),
    .RANK_W    (RANK_W)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_rank  (cmd_rank),
    .hit_vec   (hit_vec)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    rpd_idle_timer #(
      .IDLE_RELOAD (IDLE_RELOAD)
    ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (reload[r]),
      .tick    (tick),
      .expired (idle_zero[r])
    );

    rpd_rank_fsm #(
      .EXIT_LAT (EXIT_LAT)
    ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle_zero (idle_zero[r]),
      .hit       (hit_vec[r]),
      .pend      (pend_vec[r]),
      .reload    (reload[r]),
      .enter_p   (pd_enter[r]),
      .exit_p    (pd_exit[r]),
      .stall     (wake_stall[r]),
      .in_pd     (in_pd[r])
    );
  end

  // R1: nothing is signalled in the first cycle out of reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> ((in_pd == '0) && (pd_enter == '0) && (pd_exit == '0)));

  // R6: a pending command to a powered-down rank causes an exit next cycle
  p_pend_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & in_pd) != '0) |=> ((pd_exit & $past(pend_vec & in_pd)) == $past(pend_vec & in_pd)));

endmodule

// File: tb/rank_pd_ctrl_tb_top.sv
`timescale 1ns/1ps
module rank_pd_ctrl_tb_top;

  localparam int N   = 4;
  localparam int RW  = 2;
  localparam int LAT = 6;

  logic          clk;
  logic          rst_n;
  logic          tick;
  logic          cmd_valid;
  logic [RW-1:0] cmd_rank;
  logic [N-1:0]  pend_vec;
  logic [N-1:0]  pd_enter, pd_exit, wake_stall, in_pd;

  rank_pd_ctrl #(.NUM_RANKS(N), .IDLE_RELOAD(8), .EXIT_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_rank(cmd_rank), .pend_vec(pend_vec), .pd_enter(pd_enter),
    .pd_exit(pd_exit), .wake_stall(wake_stall), .in_pd(in_pd)
  );

  typedef struct packed {
    int cyc;
    int rank;
    bit is_exit;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   stall_cnt [N];
  bit   done = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, expv);
    end
  endtask

  task automatic push(input int c, input int r, input bit ex);
    exp_t e;
    e.cyc = c; e.rank = r; e.is_exit = ex;
    exp_q.push_back(e);
  endtask

  task automatic match_evt(input int r, input bit ex);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R4/R6 unexpected event rank=%0d exit=%0d cyc=%0d actual=1 expected=0",
               r, ex, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.cyc != cyc || e.rank != r || e.is_exit != ex) begin
        errors++;
        $display("FAIL R4/R6 event actual=(cyc %0d rank %0d exit %0d) expected=(cyc %0d rank %0d exit %0d)",
                 cyc, r, ex, e.cyc, e.rank, e.is_exit);
      end
    end
  endtask

  // monitor: pop and compare every pulse, count stall cycles
  always @(negedge clk) begin
    if (rst_n) begin
      for (int r = 0; r < N; r++) begin
        if (pd_exit[r])    match_evt(r, 1'b1);
        if (pd_enter[r])   match_evt(r, 1'b0);
        if (wake_stall[r]) stall_cnt[r]++;
      end
    end
  end

  task automatic wait_cyc(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    for (int r = 0; r < N; r++) stall_cnt[r] = 0;
    rst_n = 0; tick = 1; pend_vec = 4'b1110; cmd_valid = 0; cmd_rank = '0;
    repeat (3) @(negedge clk);
    chk("R1 in_pd", int'(in_pd), 0);
    chk("R1 pd_enter", int'(pd_enter), 0);
    chk("R1 pd_exit", int'(pd_exit), 0);
    chk("R1 wake_stall", int'(wake_stall), 0);

    push(9, 0, 1'b0);
    rst_n = 1;
    wait_cyc(8);
    chk("R4 no entry before timer expires", int'(in_pd), 0);
    wait_cyc(12);
    chk("R5 pending ranks stay active", int'(in_pd), 1);

    pend_vec = 4'b1111;
    push(13, 0, 1'b1);
    wait_cyc(13);
    chk("R6 status cleared on exit", int'(in_pd[0]), 0);
    chk("R7 stall on exit", int'(wake_stall), 1);
    pend_vec = 4'b1110;
    push(22, 0, 1'b0);
    wait_cyc(22);
    chk("R7 stall length rank0", stall_cnt[0], LAT);
    chk("R4 re-entry after reload", int'(in_pd), 1);

    c = cyc;
    cmd_valid = 1; cmd_rank = 2'd1; pend_vec = 4'b1100;
    push(c + 10, 1, 1'b0);
    @(negedge clk);
    cmd_valid = 0; cmd_rank = 2'd2;
    wait_cyc(c + 9);
    chk("R2 still active before reload count", int'(in_pd[1]), 0);
    wait_cyc(c + 10);
    chk("R2 entry after reload count", int'(in_pd[1]), 1);

    c = cyc;
    pend_vec = 4'b1000;
    push(c + 1, 2, 1'b0);
    wait_cyc(c + 1);
    chk("R9 invalid rank field ignored", int'(in_pd[2]), 1);

    c = cyc;
    tick = 0; cmd_valid = 1; cmd_rank = 2'd3; pend_vec = 4'b0000;
    push(c + 30, 3, 1'b0);
    @(negedge clk);
    cmd_valid = 0;
    wait_cyc(c + 21);
    chk("R3 no countdown without tick", int'(in_pd[3]), 0);
    tick = 1;
    wait_cyc(c + 29);
    chk("R3 one tick short", int'(in_pd[3]), 0);
    wait_cyc(c + 30);
    chk("R3 entry after ticks", int'(in_pd[3]), 1);

    c = cyc;
    cmd_valid = 1; cmd_rank = 2'd2;
    push(c + 1, 2, 1'b1);
    push(c + 10, 2, 1'b0);
    @(negedge clk);
    cmd_valid = 0;
    chk("R6 issue wakes rank2", int'(in_pd[2]), 0);
    chk("R7 rank2 stalls", int'(wake_stall[2]), 1);
    wait_cyc(c + 10);
    chk("R7 stall length rank2", stall_cnt[2], LAT);
    chk("R6 rank2 back down", int'(in_pd[2]), 1);

    c = cyc;
    pend_vec = 4'b0011;
    push(c + 1, 0, 1'b1);
    push(c + 1, 1, 1'b1);
    push(c + 10, 0, 1'b0);
    push(c + 10, 1, 1'b0);
    @(negedge clk);
    pend_vec = 4'b0000;
    chk("R8 two ranks stall together", int'(wake_stall), 3);
    chk("R8 other ranks untouched", int'(in_pd), 12);
    wait_cyc(c + 12);
    chk("R8 all ranks down", int'(in_pd), 15);
    chk("R8 all expected events seen", exp_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule